// File: doc/BRIEF.md
# Shared-Pin Parallel Port Controller

This block owns eight device pins that are shared between a synchronous serial peripheral, two asynchronous serial transmitters and a general-purpose parallel port. Software configures it through four 16-bit registers on a simple register bus. The registers choose which serial-capable pins belong to the peripheral and which belong to the port, set the direction of every pin, and hold an output latch. A fourth, read-only register reports the state of the pins.

Pins 0 to NPINS-NUM_TX-1 can be handed to the synchronous peripheral. The top NUM_TX pins are the transmit pins of the asynchronous channels: pin NPINS-NUM_TX+k belongs to channel k. While a channel's transmitter is enabled, its pin is driven by that channel whatever the direction setting says. When the transmitter is off, the pin behaves as a port pin.

Pad inputs are resynchronised through two flip-flops before any readback. Reading the data register returns the pin for port inputs and the latch for every other bit. The latch can be written while a pin is still an input, so software can preload safe data before it turns the pin into an output.

Top module: `spp_top`

## Requirements
- R1: After reset, the assignment, direction and latch registers read 0, and every pad_oe bit is 0.
- R2: A port-owned pin's pad_oe equals its direction bit (1 = output, 0 = input). A pin owned by the synchronous peripheral has pad_oe = direction bit AND per_oe. A pin whose direction bit is 0 is never driven, except in the case covered by R7.
- R3: A port-owned pin drives its latch bit on pad_out. A pin is port-owned when it is serial-capable with an assignment bit of 0, or when it is a transmit pin whose transmitter is off.
- R4: Assignment bit i (for i below NPINS-NUM_TX) set to 1 routes per_out[i] to pad_out[i]. Bits at and above NPINS-NUM_TX read 0 and ignore writes. The assignment register never affects the transmit pins.
- R5: A write to the data register updates the latch whatever the pin directions are. Reading the data register returns the synchronised pin for bits that are port-owned inputs, and the latch for all other bits.
- R6: Reading the pin-state register returns the synchronised pins whatever the direction. Writes to it change no register.
- R7: While tx_en[k] is 1, pin NPINS-NUM_TX+k has pad_oe = 1 and pad_out = tx_out[k], regardless of its direction bit.
- R8: Read data bits from NPINS up to BUS_W-1 are always 0, and write data in those bits is ignored.
- R9: A change on pad_in is first seen in register reads after exactly two rising clock edges.
- R10: The register selects are reg_addr 0 for assignment, 1 for direction, 2 for data/latch and 3 for pin state. Writes take effect on the clock edge where reg_wr is 1. Reads are combinational from reg_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | BUS_W | Write data |
| reg_rdata | output | BUS_W | Read data for the selected register |
| per_out | input | NPINS-NUM_TX | Synchronous peripheral output values |
| per_oe | input | NPINS-NUM_TX | Synchronous peripheral drive requests |
| tx_en | input | NUM_TX | Transmitter enable, one bit per asynchronous channel |
| tx_out | input | NUM_TX | Transmit data, one bit per asynchronous channel |
| pad_in | input | NPINS | Raw pad input values |
| pad_out | output | NPINS | Value presented to each pad |
| pad_oe | output | NPINS | Output enable for each pad |

## Verification
The bound checker checks several rules on every cycle. It checks that an enabled transmitter takes over its pin, that a port-owned pin follows its direction and latch bits, that a pin set as an input stays undriven, and that reserved read bits are zero. It also checks that the pin-state view matches the synchronised pad values with two cycles of delay, and that writes to the pin-state register leave all state unchanged. Only the bench scenarios can show the mixed ownership patterns in use. These include the combined peripheral and direction gating of output enables and the per-bit switch between pin and latch in the data readback. The bench also covers the preload-then-enable sequence, the masking of unused assignment bits and the exact two-edge input latency.

// File: rtl/spp_pkg.sv
package spp_pkg;

  typedef enum logic [1:0] {
    SEL_ASSIGN = 2'd0,
    SEL_DIR    = 2'd1,
    SEL_DATA   = 2'd2,
    SEL_PINS   = 2'd3
  } spp_sel_e;

  // Port ownership of one pin: transmit pins follow their transmitter,
  // serial-capable pins follow their assignment bit.
  function automatic logic pin_is_port(input logic is_txd,
                                       input logic asg_bit,
                                       input logic tx_on);
    return is_txd ? !tx_on : !asg_bit;
  endfunction

  // Data register view of one bit: live pin for port inputs, latch otherwise.
  function automatic logic data_view(input logic own,
                                     input logic dir_bit,
                                     input logic lat_bit,
                                     input logic pin_bit);
    return (own && !dir_bit) ? pin_bit : lat_bit;
  endfunction

endpackage

// File: rtl/spp_sync.sv
module spp_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;
endmodule

// File: rtl/spp_regs.sv
module spp_regs
  import spp_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int NSPI  = 6,
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [BUS_W-1:0] wdata,
  output logic [NSPI-1:0]  asg_q,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] lat_q
);
  logic unused_hi;
  assign unused_hi = ^wdata[BUS_W-1:NPINS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asg_q <= '0;
      dir_q <= '0;
      lat_q <= '0;
    end else if (wr) begin
      case (spp_sel_e'(addr))
        SEL_ASSIGN: asg_q <= wdata[NSPI-1:0];
        SEL_DIR:    dir_q <= wdata[NPINS-1:0];
        SEL_DATA:   lat_q <= wdata[NPINS-1:0];
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/spp_pinmux.sv
module spp_pinmux
  import spp_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int NUM_TX = 2
) (
  input  logic [NPINS-NUM_TX-1:0] asg_q,
  input  logic [NPINS-1:0]        dir_q,
  input  logic [NPINS-1:0]        lat_q,
  input  logic [NPINS-NUM_TX-1:0] per_out,
  input  logic [NPINS-NUM_TX-1:0] per_oe,
  input  logic [NUM_TX-1:0]       tx_en,
  input  logic [NUM_TX-1:0]       tx_out,
  output logic [NPINS-1:0]        pad_out,
  output logic [NPINS-1:0]        pad_oe,
  output logic [NPINS-1:0]        port_own
);
  localparam int NSPI = NPINS - NUM_TX;

  for (genvar i = 0; i < NSPI; i++) begin : g_ser
    assign port_own[i] = pin_is_port(1'b0, asg_q[i], 1'b0);
    assign pad_out[i]  = port_own[i] ? lat_q[i] : per_out[i];
    assign pad_oe[i]   = port_own[i] ? dir_q[i] : (dir_q[i] & per_oe[i]);
  end

  for (genvar k = 0; k < NUM_TX; k++) begin : g_txd
    localparam int P = NSPI + k;
    assign port_own[P] = pin_is_port(1'b1, 1'b0, tx_en[k]);
    assign pad_out[P]  = port_own[P] ? lat_q[P] : tx_out[k];
    assign pad_oe[P]   = port_own[P] ? dir_q[P] : 1'b1;
  end
endmodule

// File: rtl/spp_top.sv
module spp_top
  import spp_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int NUM_TX = 2,
  parameter int BUS_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              reg_addr,
  input  logic                    reg_wr,
  input  logic [BUS_W-1:0]        reg_wdata,
  output logic [BUS_W-1:0]        reg_rdata,
  input  logic [NPINS-NUM_TX-1:0] per_out,
  input  logic [NPINS-NUM_TX-1:0] per_oe,
  input  logic [NUM_TX-1:0]       tx_en,
  input  logic [NUM_TX-1:0]       tx_out,
  input  logic [NPINS-1:0]        pad_in,
  output logic [NPINS-1:0]        pad_out,
  output logic [NPINS-1:0]        pad_oe
);
  localparam int NSPI = NPINS - NUM_TX;

  logic [NSPI-1:0]  asg_q;
  logic [NPINS-1:0] dir_q;
  logic [NPINS-1:0] lat_q;
  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] port_own;

  spp_regs #(.NPINS(NPINS), .NSPI(NSPI), .BUS_W(BUS_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .asg_q (asg_q),
    .dir_q (dir_q),
    .lat_q (lat_q)
  );

  spp_sync #(.W(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pin_sync)
  );

  spp_pinmux #(.NPINS(NPINS), .NUM_TX(NUM_TX)) u_mux (
    .asg_q    (asg_q),
    .dir_q    (dir_q),
    .lat_q    (lat_q),
    .per_out  (per_out),
    .per_oe   (per_oe),
    .tx_en    (tx_en),
    .tx_out   (tx_out),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .port_own (port_own)
  );

  always_comb begin
    reg_rdata = '0;
    case (spp_sel_e'(reg_addr))
      SEL_ASSIGN: reg_rdata[NSPI-1:0]  = asg_q;
      SEL_DIR:    reg_rdata[NPINS-1:0] = dir_q;
      SEL_DATA: begin
        for (int i = 0; i < NPINS; i++) begin
          reg_rdata[i] = data_view(port_own[i], dir_q[i], lat_q[i], pin_sync[i]);
        end
      end
      default:    reg_rdata[NPINS-1:0] = pin_sync;
    endcase
  end
endmodule

// File: rtl/spp_checker.sv
module spp_checker
  import spp_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int NUM_TX = 2,
  parameter int BUS_W  = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [1:0]              reg_addr,
  input logic                    reg_wr,
  input logic [BUS_W-1:0]        reg_wdata,
  input logic [BUS_W-1:0]        reg_rdata,
  input logic [NPINS-1:0]        pad_in,
  input logic [NPINS-1:0]        pad_out,
  input logic [NPINS-1:0]        pad_oe,
  input logic [NUM_TX-1:0]       tx_en,
  input logic [NUM_TX-1:0]       tx_out,
  input logic [NPINS-NUM_TX-1:0] asg_q,
  input logic [NPINS-1:0]        dir_q,
  input logic [NPINS-1:0]        lat_q,
  input logic [NPINS-1:0]        pin_sync,
  input logic [NPINS-1:0]        port_own
);
  localparam int NSPI = NPINS - NUM_TX;

  logic [1:0] cyc_q;
  logic       unused_ok;
  assign unused_ok = ^reg_wdata[BUS_W-1:NPINS];

  always_ff @(posedge clk) begin
    if (!rst_n)          cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  for (genvar k = 0; k < NUM_TX; k++) begin : g_tx
    p_txd_forced_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_en[k] |-> (pad_oe[NSPI+k] && pad_out[NSPI+k] == tx_out[k]));
    p_txd_idle_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_en[k] && !dir_q[NSPI+k]) |-> !pad_oe[NSPI+k]);
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    p_port_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
      port_own[i] |-> (pad_oe[i] == dir_q[i] && pad_out[i] == lat_q[i]));
  end

  for (genvar i = 0; i < NSPI; i++) begin : g_ser
    p_input_undriven_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_q[i] |-> !pad_oe[i]);
  end

  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[BUS_W-1:NPINS] == '0);

  p_pins_view_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd3) |-> (reg_rdata[NPINS-1:0] == pin_sync));

  p_pins_wr_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd3) |=> ($stable(dir_q) && $stable(lat_q) && $stable(asg_q)));

  p_latch_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2) |=> (lat_q == $past(reg_wdata[NPINS-1:0])));

  p_sync_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 2'd2) |-> (pin_sync == $past(pad_in, 2)));

  p_asg_hi_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd0) |-> (reg_rdata[NPINS-1:NSPI] == '0));
endmodule

bind spp_top spp_checker #(.NPINS(NPINS), .NUM_TX(NUM_TX), .BUS_W(BUS_W)) u_chk (.*);

// File: tb/tb_spp_top.sv
module tb_spp_top;
  localparam int NPINS = 8;
  localparam int NUM_TX = 2;
  localparam int BUS_W = 16;
  localparam int NSPI = NPINS - NUM_TX;

  typedef struct packed {
    logic [5:0] asg;
    logic [7:0] dir;
    logic [7:0] lat;
    logic [1:0] ten;
    logic [1:0] tout;
    logic [5:0] pout;
    logic [5:0] poe;
    logic [7:0] pad;
    logic [7:0] xout;
    logic [7:0] xoe;
    logic [7:0] xdata;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t TABLE [NVEC] = '{
    '{6'h00, 8'h00, 8'h00, 2'b00, 2'b00, 6'h00, 6'h00, 8'hA5, 8'h00, 8'h00, 8'hA5},
    '{6'h00, 8'hFF, 8'h3C, 2'b00, 2'b00, 6'h00, 6'h00, 8'hC3, 8'h3C, 8'hFF, 8'h3C},
    '{6'h0F, 8'hF0, 8'h5A, 2'b00, 2'b00, 6'h09, 6'h3F, 8'hFF, 8'h59, 8'hF0, 8'h5A},
    '{6'h3F, 8'h0F, 8'h00, 2'b01, 2'b01, 6'h2A, 6'h05, 8'h96, 8'h6A, 8'h45, 8'h80},
    '{6'h00, 8'h00, 8'hFF, 2'b11, 2'b10, 6'h00, 6'h00, 8'h00, 8'hBF, 8'hC0, 8'hC0},
    '{6'h3F, 8'h00, 8'h81, 2'b00, 2'b11, 6'h3F, 6'h3F, 8'h5A, 8'hBF, 8'h00, 8'h41}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       reg_addr = '0;
  logic             reg_wr = 1'b0;
  logic [BUS_W-1:0] reg_wdata = '0;
  logic [BUS_W-1:0] reg_rdata;
  logic [NSPI-1:0]  per_out = '0;
  logic [NSPI-1:0]  per_oe = '0;
  logic [NUM_TX-1:0] tx_en = '0;
  logic [NUM_TX-1:0] tx_out = '0;
  logic [NPINS-1:0] pad_in = '0;
  logic [NPINS-1:0] pad_out;
  logic [NPINS-1:0] pad_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spp_top #(.NPINS(NPINS), .NUM_TX(NUM_TX), .BUS_W(BUS_W)) dut (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);

    // R1: reset state
    read_reg(2'd0, rd); check("R1 assign", rd, 16'h0000);
    read_reg(2'd1, rd); check("R1 dir", rd, 16'h0000);
    read_reg(2'd2, rd); check("R1 data", rd, 16'h0000);
    check("R1 pad_oe", {8'h00, pad_oe}, 16'h0000);
    pad_in = 8'hFF;
    write_reg(2'd1, 16'h00FF);
    read_reg(2'd2, rd); check("R1 latch", rd, 16'h0000);
    write_reg(2'd1, 16'h0000);

    // Table walk: R2 R3 R4 R7 on pads, R5 data view, R6 pin view, R10 map
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      pad_in = TABLE[v].pad; per_out = TABLE[v].pout; per_oe = TABLE[v].poe;
      tx_en = TABLE[v].ten; tx_out = TABLE[v].tout;
      write_reg(2'd0, {10'h000, TABLE[v].asg});
      write_reg(2'd1, {8'h00, TABLE[v].dir});
      write_reg(2'd2, {8'h00, TABLE[v].lat});
      @(negedge clk);
      check("R3/R4/R7 pad_out", {8'h00, pad_out}, {8'h00, TABLE[v].xout});
      check("R2/R7 pad_oe", {8'h00, pad_oe}, {8'h00, TABLE[v].xoe});
      read_reg(2'd2, rd); check("R5 data view", rd, {8'h00, TABLE[v].xdata});
      read_reg(2'd3, rd); check("R6 pin view", rd, {8'h00, TABLE[v].pad});
      read_reg(2'd1, rd); check("R10 dir select", rd, {8'h00, TABLE[v].dir});
    end

    // R5: preload latch while inputs, then enable outputs
    tx_en = '0; per_oe = '0; per_out = '0; pad_in = 8'h00;
    write_reg(2'd0, 16'h0000);
    write_reg(2'd1, 16'h0000);
    write_reg(2'd2, 16'h00A5);
    @(negedge clk);
    read_reg(2'd2, rd); check("R5 input reads pin", rd, 16'h0000);
    check("R5 no drive yet", {8'h00, pad_oe}, 16'h0000);
    write_reg(2'd1, 16'h00FF);
    check("R5 preloaded out", {8'h00, pad_out}, 16'h00A5);
    check("R5 oe on", {8'h00, pad_oe}, 16'h00FF);
    read_reg(2'd2, rd); check("R5 output reads latch", rd, 16'h00A5);

    // R4 / R8: masked and reserved bits
    write_reg(2'd0, 16'hFFFF);
    read_reg(2'd0, rd); check("R4 assign mask", rd, 16'h003F);
    write_reg(2'd1, 16'hFFFF);
    read_reg(2'd1, rd); check("R8 reserved dir", rd, 16'h00FF);
    write_reg(2'd2, 16'hFF12);
    read_reg(2'd2, rd); check("R8 reserved data", rd, 16'h0012);

    // R6: writes to the pin-state register change nothing
    write_reg(2'd0, 16'h0000);
    write_reg(2'd1, 16'h0000);
    write_reg(2'd3, 16'hFFFF);
    read_reg(2'd0, rd); check("R6 assign kept", rd, 16'h0000);
    read_reg(2'd1, rd); check("R6 dir kept", rd, 16'h0000);
    check("R6 pads undriven", {8'h00, pad_oe}, 16'h0000);
    write_reg(2'd1, 16'h00FF);
    read_reg(2'd2, rd); check("R6 latch kept", rd, 16'h0012);

    // R9: two-edge input latency
    read_reg(2'd3, rd); check("R9 baseline", rd, 16'h0000);
    pad_in = 8'h3C;
    read_reg(2'd3, rd); check("R9 zero edges", rd, 16'h0000);
    @(negedge clk);
    read_reg(2'd3, rd); check("R9 one edge", rd, 16'h0000);
    @(negedge clk);
    read_reg(2'd3, rd); check("R9 two edges", rd, 16'h003C);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule